// File: doc/BRIEF.md
# PWM Fault Override Gate

This block sits between an eight-channel PWM generator and the output pins. Each cycle it either passes the generator's waveforms through or, while a fault is in force, replaces selected channels with a per-channel safe idle level. A fault comes from either of two external fault pins, or from a debug-halt indicator when that source is enabled. The fault pins are asynchronous. Their active level is set by configuration, and they are resynchronized before use.

A scope select decides which channels are shut off. With full shutdown, every channel goes idle. Otherwise the top two channels keep running, so one channel pair can stay active through a fault. The fault state can be released in two ways. In latched mode, software issues a clear strobe once every source has gone quiet. In cycle-by-cycle mode, the state drops at the next PWM period boundary after the sources clear. Three sticky flags record which sources caused the shutdown, and the same clear strobe resets them.

Top module: `pwm_fault_gate`

## Requirements
- R1: A fault pin change reaches the fault state only through a two-stage synchronizer. A pin asserted before clock edge k raises `fault_active` after edge k+2, and not earlier.
- R2: A fault pin is active when its level equals its polarity bit: `cfg_pol_a` for pin A and `cfg_pol_b` for pin B, where 1 means active high and 0 means active low.
- R3: The fault state is entered when pin A alone, pin B alone, or both pins are active.
- R4: With `cfg_full_stop` = 1 and `fault_active` = 1, every bit of `pwm_out` equals the matching bit of `cfg_idle`, whatever the generator inputs are.
- R5: With `cfg_full_stop` = 0 and `fault_active` = 1, channels 5..0 take their idle level, and `pwm_out[7:6]` follow `pwm_in[7:6]`.
- R6: The idle level of channel i is `cfg_idle[i]`: 0 drives the channel low and 1 drives it high.
- R7: With `cfg_brk_en` = 1, a high `dbg_halt` sampled at a clock edge sets `fault_active` after that edge.
- R8: With `cfg_brk_en` = 0, `dbg_halt` changes neither the outputs nor the fault state.
- R9: With `cfg_latched` = 1, the fault state holds after every source goes inactive. It clears only at an edge where `clr_strobe` = 1 and no source is active. A clear strobe that arrives while a source is active has no effect.
- R10: With `cfg_latched` = 0, the fault state clears at an edge where `period_tick` = 1 and no source is active. In this mode `clr_strobe` does not release the fault state.
- R11: `flag_a`, `flag_b` and `flag_brk` are set by their own source and stay set. At an edge with `clr_strobe` = 1, a flag whose source is inactive clears.
- R12: With `fault_active` = 0, `pwm_out` equals `pwm_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 8 | Raw generator waveforms |
| flt_pin_a | input | 1 | Asynchronous fault pin A |
| flt_pin_b | input | 1 | Asynchronous fault pin B |
| dbg_halt | input | 1 | Debug halt indicator, synchronous to clk |
| cfg_full_stop | input | 1 | 1: all channels shut off; 0: channels 7:6 keep running |
| cfg_brk_en | input | 1 | Treat debug halt as a fault |
| cfg_latched | input | 1 | 1: latched release; 0: cycle-by-cycle release |
| cfg_pol_a | input | 1 | Active level of pin A |
| cfg_pol_b | input | 1 | Active level of pin B |
| cfg_idle | input | 8 | Per-channel idle level |
| period_tick | input | 1 | PWM period boundary pulse |
| clr_strobe | input | 1 | Fault and flag clear pulse |
| pwm_out | output | 8 | Gated waveforms to pins |
| fault_active | output | 1 | Fault state |
| flag_a | output | 1 | Sticky: pin A caused a fault |
| flag_b | output | 1 | Sticky: pin B caused a fault |
| flag_brk | output | 1 | Sticky: debug halt caused a fault |

## Verification
The hardest case to reach is a release request that arrives while a source is still active but only inside the synchronizer. The pin has already dropped, yet the delayed copy still holds the fault, so a clear strobe or period tick in that cycle must be refused. Directed sequences drop a pin and pulse the clear or tick one cycle later, inside the two-cycle synchronizer window. Seeded random traffic adds overlapping releases and source changes, and a cycle-accurate bench model judges every cycle.

// File: rtl/pfg_pkg.sv
// Package: shared types and sizes for the PWM fault override gate.
// Assumes eight channels and three fault sources.
package pfg_pkg;
    localparam int unsigned NUM_CH   = 8;
    localparam int unsigned NUM_KEEP = 2;
    localparam int unsigned SYNC_LEN = 2;

    // One bit per fault source, already reduced to "active" meaning.
    typedef struct packed {
        logic brk;
        logic b;
        logic a;
    } flt_src_t;
endpackage

// File: rtl/pfg_sync.sv
// Module: pfg_sync
// Multi-stage flop chain that brings an asynchronous level into the clk
// domain. Assumes the input is a slow level. Resets to 0, meaning inactive.
module pfg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level down the chain one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_fault_ctl.sv
// Module: pfg_fault_ctl
// Holds the fault state and the sticky cause flags. Assumes the sources are
// already synchronous and active high. Any active source sets the state.
// Release happens through clr (latched mode) or tick (cycle-by-cycle mode),
// and only while all sources are quiet.
module pfg_fault_ctl
    import pfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  flt_src_t srcs,
    input  logic     latched,
    input  logic     clr,
    input  logic     tick,
    output logic     fault,
    output flt_src_t flags
);
    logic any_src;
    logic release_ok;

    // Combine the sources and pick the release event for the mode.
    always_comb begin
        any_src    = |srcs;
        release_ok = latched ? clr : tick;
    end

    // Fault state register: set wins over release.
    always_ff @(posedge clk) begin
        if (!rst_n)          fault <= 1'b0;
        else if (any_src)    fault <= 1'b1;
        else if (release_ok) fault <= 1'b0;
    end

    // Sticky cause flags: each is set by its source and cleared by clr.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= srcs | (flags & ~{3{clr}});
    end

    // R3, R7: any active source puts the block in fault on the next edge.
    a_r3_src_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> fault);
    // R9: latched mode holds the fault without a clear strobe.
    a_r9_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && fault && !clr) |=> fault);
    // R10: cycle-by-cycle mode releases on a quiet tick.
    a_r10_tick_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && fault && tick && !any_src) |=> !fault);
    // R10: the clear strobe alone does not release in cycle-by-cycle mode.
    a_r10_clr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && fault && !tick) |=> fault);
    // R11: a source leaves its flag set.
    a_r11_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
        srcs.a |=> flags.a);
    a_r11_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
        srcs.b |=> flags.b);
    a_r11_flag_brk: assert property (@(posedge clk) disable iff (!rst_n)
        srcs.brk |=> flags.brk);
endmodule

// File: rtl/pfg_gate.sv
// Module: pfg_gate
// Purely combinational output gating. Channels in the shutdown set take
// their idle level while the fault state is high. The upper KEEP channels
// are in the set only when full stop is selected.
module pfg_gate #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned KEEP = 2
) (
    input  logic           fault,
    input  logic           full_stop,
    input  logic [NCH-1:0] idle,
    input  logic [NCH-1:0] pwm_in,
    output logic [NCH-1:0] pwm_out
);
    localparam int unsigned LOW_CNT = NCH - KEEP;

    logic [NCH-1:0] force_en;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            if (i < LOW_CNT) begin : g_always
                // Lower channel: forced by any fault.
                always_comb force_en[i] = fault;
            end else begin : g_kept
                // Upper channel: forced only when full stop is selected.
                always_comb force_en[i] = fault & full_stop;
            end
            // Select the idle level or the generator waveform.
            always_comb pwm_out[i] = force_en[i] ? idle[i] : pwm_in[i];
        end
    endgenerate
endmodule

// File: rtl/pwm_fault_gate.sv
// Module: pwm_fault_gate (top)
// Fault override between the PWM generator and the pins. The fault pins
// are first mapped to "active" by their polarity and then synchronized in
// two stages. dbg_halt is assumed synchronous to clk.
module pwm_fault_gate
    import pfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic              flt_pin_a,
    input  logic              flt_pin_b,
    input  logic              dbg_halt,
    input  logic              cfg_full_stop,
    input  logic              cfg_brk_en,
    input  logic              cfg_latched,
    input  logic              cfg_pol_a,
    input  logic              cfg_pol_b,
    input  logic [NUM_CH-1:0] cfg_idle,
    input  logic              period_tick,
    input  logic              clr_strobe,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              fault_active,
    output logic              flag_a,
    output logic              flag_b,
    output logic              flag_brk
);
    logic     a_raw, b_raw, a_sync, b_sync;
    flt_src_t srcs, flags;

    // Map each pin to an active-high level before synchronization.
    always_comb begin
        a_raw = (flt_pin_a == cfg_pol_a);
        b_raw = (flt_pin_b == cfg_pol_b);
    end

    pfg_sync #(.STAGES(SYNC_LEN)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .d(a_raw), .q(a_sync));
    pfg_sync #(.STAGES(SYNC_LEN)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .d(b_raw), .q(b_sync));

    // Build the source vector, with the breakpoint gated by its enable.
    always_comb begin
        srcs.a   = a_sync;
        srcs.b   = b_sync;
        srcs.brk = dbg_halt & cfg_brk_en;
    end

    pfg_fault_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .srcs(srcs), .latched(cfg_latched),
        .clr(clr_strobe), .tick(period_tick), .fault(fault_active),
        .flags(flags));

    pfg_gate #(.NCH(NUM_CH), .KEEP(NUM_KEEP)) u_gate (
        .fault(fault_active), .full_stop(cfg_full_stop), .idle(cfg_idle),
        .pwm_in(pwm_in), .pwm_out(pwm_out));

    assign flag_a   = flags.a;
    assign flag_b   = flags.b;
    assign flag_brk = flags.brk;

    // R4: full stop forces every output to its idle level.
    a_r4_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_active && cfg_full_stop) |-> (pwm_out == cfg_idle));
    // R5: partial stop keeps the upper channels running.
    a_r5_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_full_stop |-> (pwm_out[NUM_CH-1:NUM_CH-NUM_KEEP] ==
                            pwm_in[NUM_CH-1:NUM_CH-NUM_KEEP]));
    // R12: without a fault the outputs follow the generator.
    a_r12_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_active |-> (pwm_out == pwm_in));
    // R8: a disabled breakpoint never sets its flag.
    a_r8_brk_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_brk_en && !flag_brk) |=> !flag_brk);
endmodule

// File: tb/sim_pwm_fault_gate.sv
module sim_pwm_fault_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pwm_in = '0, cfg_idle = '0, pwm_out;
    logic fa = 0, fb = 0, halt = 0, full = 1, brk_en = 0, latched = 1;
    logic pa = 1, pb = 1, tick = 0, clr = 0;
    logic fault_active, flag_a, flag_b, flag_brk;
    int   n_chk = 0, n_fail = 0, cyc = 0;

    // Bench model state
    logic m_a1, m_a2, m_b1, m_b2, m_flt, m_fa, m_fb, m_fk;

    always #10 clk = ~clk;   // 50 MHz

    pwm_fault_gate u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .flt_pin_a(fa),
        .flt_pin_b(fb), .dbg_halt(halt), .cfg_full_stop(full),
        .cfg_brk_en(brk_en), .cfg_latched(latched), .cfg_pol_a(pa),
        .cfg_pol_b(pb), .cfg_idle(cfg_idle), .period_tick(tick),
        .clr_strobe(clr), .pwm_out(pwm_out), .fault_active(fault_active),
        .flag_a(flag_a), .flag_b(flag_b), .flag_brk(flag_brk));

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        logic act, brk_act;
        if (!rst_n) begin
            {m_a1, m_a2, m_b1, m_b2, m_flt, m_fa, m_fb, m_fk} <= '0;
        end else begin
            brk_act = halt & brk_en;
            act = m_a2 | m_b2 | brk_act;
            m_a1 <= (fa == pa);  m_a2 <= m_a1;
            m_b1 <= (fb == pb);  m_b2 <= m_b1;
            if (act) m_flt <= 1'b1;
            else if (latched ? clr : tick) m_flt <= 1'b0;
            m_fa <= m_a2 | (m_fa & ~clr);
            m_fb <= m_b2 | (m_fb & ~clr);
            m_fk <= brk_act | (m_fk & ~clr);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_out();
        logic [7:0] e;
        for (int i = 0; i < 8; i++)
            e[i] = (m_flt && (full || i < 6)) ? cfg_idle[i] : pwm_in[i];
        return e;
    endfunction

    // Wait to the next falling edge and compare every output with the model.
    task automatic step();
        @(negedge clk);
        chk(pwm_out, exp_out(), !m_flt ? "R12" : (full ? "R4/R6" : "R5/R6"));
        chk({7'd0, fault_active}, {7'd0, m_flt}, latched ? "R9 state" : "R10 state");
        chk({5'd0, flag_brk, flag_b, flag_a}, {5'd0, m_fk, m_fb, m_fa}, "R11 flags");
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd2024));
        steps(2);
        rst_n = 1'b1;
        chk({7'd0, fault_active}, 8'd0, "reset state");
        pwm_in = 8'hA5; cfg_idle = 8'h3C;
        step();
        chk(pwm_out, 8'hA5, "R12 pass");

        // R1/R3: pin A alone, active high, timing through synchronizer
        fa = 1; step(); step();
        chk({7'd0, fault_active}, 8'd0, "R1 not before sync");
        step();
        chk({7'd0, fault_active}, 8'd1, "R1 R3 pin A sets fault");
        chk(pwm_out, 8'h3C, "R4 R6 full stop idle");
        // R9: release refused while sync copy still active
        fa = 0; clr = 1; step(); clr = 0; step();
        chk({7'd0, fault_active}, 8'd1, "R9 clear during sync window");
        steps(3);
        chk({7'd0, fault_active}, 8'd1, "R9 latched hold");
        clr = 1; step(); clr = 0; step();
        chk({7'd0, fault_active}, 8'd0, "R9 clear releases");
        chk({7'd0, flag_a}, 8'd0, "R11 flag cleared");

        // R2/R5: pin B active low, partial stop
        pb = 0; full = 0; fb = 1; steps(2);
        fb = 0; steps(3);
        chk({7'd0, fault_active}, 8'd1, "R2 R3 pin B active low");
        pwm_in = 8'hC3;
        step();
        chk(pwm_out, {2'b11, 6'h3C}, "R5 upper kept");
        chk({6'd0, flag_b, flag_a}, 8'd2, "R11 only flag B");
        // R10: cycle mode, tick refused while active, clr ignored
        latched = 0; clr = 1; tick = 1; step(); clr = 0; tick = 0; step();
        chk({7'd0, fault_active}, 8'd1, "R10 active source holds");
        fb = 1; steps(3); clr = 1; step(); clr = 0; step();
        chk({7'd0, fault_active}, 8'd1, "R10 clr ignored");
        tick = 1; step(); tick = 0; step();
        chk({7'd0, fault_active}, 8'd0, "R10 tick releases");

        // R8 / R7: breakpoint source
        brk_en = 0; halt = 1; steps(3);
        chk({7'd0, fault_active}, 8'd0, "R8 halt ignored");
        chk(pwm_out, pwm_in, "R8 outputs follow");
        chk({7'd0, flag_brk}, 8'd0, "R8 no flag");
        brk_en = 1; step();
        chk({7'd0, fault_active}, 8'd1, "R7 halt sets fault");
        chk({7'd0, flag_brk}, 8'd1, "R7 R11 brk flag");
        halt = 0; tick = 1; clr = 1; step(); tick = 0; clr = 0; step();

        // Constrained random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            pwm_in = 8'($urandom);
            if ($urandom % 16 == 0) fa = ~fa;
            if ($urandom % 16 == 0) fb = ~fb;
            if ($urandom % 64 == 0) cfg_idle = 8'($urandom);
            if ($urandom % 200 == 0) begin pa = ~pa; pb = ~pb; end
            if ($urandom % 100 == 0) full = ~full;
            if ($urandom % 150 == 0) latched = ~latched;
            if ($urandom % 80 == 0) brk_en = ~brk_en;
            halt  = ($urandom % 24 == 0);
            tick  = ($urandom % 10 == 0);
            clr   = ($urandom % 12 == 0);
            step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule